// File: doc/BRIEF.md
# Character-cell colour video generator

This block rasterises a screen made of programmable character cells. Each cell is six pixels wide and eight scanlines tall. A page RAM holds one 8-bit character code per screen position. A character RAM holds eight 9-bit words per code, one word per scanline of the cell. Every word carries six pixel bits and a 3-bit foreground colour, so colour can change from one scanline of a character to the next. Cleared pixels show a single background colour that applies to the whole screen.

The screen has 40 text rows. Its width is 25 or 27 cells, chosen by a mode input. The mode input is read at reset and at each frame boundary, so the width never changes part-way through a frame. The block fetches from both RAMs one cell ahead of the cell being shown, which keeps the pixel stream continuous. Both RAMs are synchronous, with one cycle of read latency.

The block has two further outputs. One is a CPU clock at half the pixel rate. The other is a non-display indicator that is high on every scanline below the text area; this is the window in which the CPU may access the video RAMs.

Top module: `charcell_vidgen`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `pix_blank` is 1, `pix_colour` is 0, `predisplay` is 0 and `cpu_clk` is 0.
- R2: `cpu_clk` inverts on every pixel clock after reset, giving half the pixel rate.
- R3: The timing is as follows. Each cell lasts 6 pixel clocks, at phases 0 to 5. A line has 30 cells, and cells 0 to 29 are counted from reset. In phase 0 of cell c on text row r, `page_addr` equals r*W + c, where W is the current width and c < W.
- R4: In phase 2 of the same cell, `chr_addr` equals code*8 + s. Here code is the page RAM word read at that address, and s is the scanline within the cell (line number mod 8).
- R5: Column c is displayed during cell c+1. In phase p, the output shows bit 5-p of the fetched word, so bit 5 comes first. If that bit is set, the output colour is bits 8:6 of the word.
- R6: The output is blank (`pix_blank`=1, `pix_colour`=0) in cells 0 and W+1 to 29, and on lines 320 to 327. Each output is registered one clock after the counter state it represents.
- R7: `predisplay` is high exactly while the line counter is in 320 to 327 (8 non-display lines, 328 lines per frame).
- R8: W is 27 when `wide_mode` is 1 and 25 when it is 0. W is sampled at reset and at the last pixel of each frame, and is held at all other times.
- R9: A clear pixel shows the value of `bg_colour` sampled at the same clock edge that registers the pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_mode | input | 1 | 1 selects 27 columns, 0 selects 25 |
| bg_colour | input | 3 | Screen-wide background colour |
| page_addr | output | 11 | Page RAM read address |
| page_data | input | 8 | Page RAM read data, one cycle after address |
| chr_addr | output | 11 | Character RAM read address {code, scanline} |
| chr_data | input | 9 | Character RAM word: [8:6] colour, [5:0] pixels |
| pix_colour | output | 3 | Pixel colour, 0 while blanked |
| pix_blank | output | 1 | High outside the active area |
| predisplay | output | 1 | High during the non-display lines |
| cpu_clk | output | 1 | Pixel clock divided by two |

## Verification
Two situations are hardest to reach from the ports. One is a change of `wide_mode` part-way through a frame. The other is the last column of a wide frame, where the page address reaches 1079 and the blanking edge moves by two cells. To reach them, the stimulus runs more than two complete frames. It raises `wide_mode` in the middle of the first frame and lowers it in the middle of the second, and it changes `bg_colour` at the same points. A cycle-accurate model in the bench tracks the raster position, the sampled width and the RAM contents. Against this model the bench checks every pixel, both RAM addresses in their fetch phases, the predisplay flag and the CPU clock.

// File: rtl/vidgen_pkg.sv
// Shared types and fetch-phase constants for the character-cell video generator.
// Assumes cells of at least five pixel phases, so the fetch steps finish before the reload.
package vidgen_pkg;
    typedef logic [2:0] colour_t;

    // phase in which the registered character RAM address is formed
    localparam int CHR_ADDR_PHASE = 1;
    // phase in which the character RAM word is captured
    localparam int WORD_LATCH_PHASE = 3;
endpackage

// File: rtl/vid_timing.sv
// Raster timing: pixel phase, cell and line counters, the text-row base address,
// the frame-latched screen width, the non-display flag and the half-rate CPU clock.
// Assumes CELL_H is a power of two, so the scanline-in-cell value is the low line bits.
module vid_timing #(
    parameter int CELL_W        = 6,
    parameter int CELL_H        = 8,
    parameter int H_TOTAL_CELLS = 30,
    parameter int TEXT_ROWS     = 40,
    parameter int V_BLANK_LINES = 8,
    parameter int COLS_NARROW   = 25,
    parameter int COLS_WIDE     = 27,
    localparam int ACT_LINES    = TEXT_ROWS * CELL_H,
    localparam int V_TOTAL      = ACT_LINES + V_BLANK_LINES,
    localparam int PH_W         = $clog2(CELL_W),
    localparam int HC_W         = $clog2(H_TOTAL_CELLS),
    localparam int LN_W         = $clog2(V_TOTAL),
    localparam int ROW_W        = $clog2(CELL_H),
    localparam int NC_W         = $clog2(COLS_WIDE + 1),
    localparam int PA_W         = $clog2(TEXT_ROWS * COLS_WIDE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wide_sel,
    output logic [PH_W-1:0]  ph,
    output logic [HC_W-1:0]  hc,
    output logic [ROW_W-1:0] row,
    output logic [PA_W-1:0]  row_base,
    output logic             disp_active,
    output logic             in_vblank,
    output logic             half_clk
);
    logic [LN_W-1:0] ln;
    logic [NC_W-1:0] ncols;
    logic            last_ph;
    logic            last_hc;
    logic            last_ln;
    logic            line_end;
    logic            frame_end;

    assign last_ph   = (ph == PH_W'(CELL_W - 1));
    assign last_hc   = (hc == HC_W'(H_TOTAL_CELLS - 1));
    assign last_ln   = (ln == LN_W'(V_TOTAL - 1));
    assign line_end  = last_ph && last_hc;
    assign frame_end = line_end && last_ln;
    assign row       = ln[ROW_W-1:0];
    assign in_vblank = (32'(ln) >= ACT_LINES);
    // the cell shown is one behind the cell being fetched
    assign disp_active = !in_vblank && (hc != '0) && (32'(hc) <= 32'(ncols));

    // pixel phase within the current cell
    always_ff @(posedge clk) begin
        if (!rst_n)       ph <= '0;
        else if (last_ph) ph <= '0;
        else              ph <= ph + 1'b1;
    end

    // cell counter along the line
    always_ff @(posedge clk) begin
        if (!rst_n)       hc <= '0;
        else if (last_ph) hc <= last_hc ? '0 : hc + 1'b1;
    end

    // line counter down the frame
    always_ff @(posedge clk) begin
        if (!rst_n)        ln <= '0;
        else if (line_end) ln <= last_ln ? '0 : ln + 1'b1;
    end

    // first page address of the current text row, stepped by the width
    always_ff @(posedge clk) begin
        if (!rst_n || frame_end)
            row_base <= '0;
        else if (line_end && row == ROW_W'(CELL_H - 1))
            row_base <= row_base + PA_W'(ncols);
    end

    // screen width, taken only at reset and at the frame boundary
    always_ff @(posedge clk) begin
        if (!rst_n || frame_end)
            ncols <= wide_sel ? NC_W'(COLS_WIDE) : NC_W'(COLS_NARROW);
    end

    // CPU clock at half the pixel rate
    always_ff @(posedge clk) begin
        if (!rst_n) half_clk <= 1'b0;
        else        half_clk <= ~half_clk;
    end

    p_cpuclk_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !half_clk |=> half_clk);
    p_cpuclk_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        half_clk |=> !half_clk);
    p_width_frame_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ncols) |-> $past(frame_end));
endmodule

// File: rtl/vid_fetch.sv
// Cell fetch: presents the page address for the cell being fetched, forms the
// character RAM address from the returned code and the scanline, and captures the word.
// Assumes both RAMs return data one clock after the address.
module vid_fetch
    import vidgen_pkg::*;
#(
    parameter int CELL_W      = 6,
    parameter int CELL_H      = 8,
    parameter int H_TOTAL_CELLS = 30,
    parameter int TEXT_ROWS   = 40,
    parameter int COLS_WIDE   = 27,
    localparam int PH_W       = $clog2(CELL_W),
    localparam int HC_W       = $clog2(H_TOTAL_CELLS),
    localparam int ROW_W      = $clog2(CELL_H),
    localparam int PA_W       = $clog2(TEXT_ROWS * COLS_WIDE),
    localparam int CA_W       = 8 + ROW_W,
    localparam int WORD_W     = CELL_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PH_W-1:0]   ph,
    input  logic [HC_W-1:0]   hc,
    input  logic [ROW_W-1:0]  row,
    input  logic [PA_W-1:0]   row_base,
    output logic [PA_W-1:0]   page_addr,
    input  logic [7:0]        page_data,
    output logic [CA_W-1:0]   chr_addr,
    input  logic [WORD_W-1:0] chr_data,
    output logic [WORD_W-1:0] next_word
);
    // page address of the cell under fetch
    assign page_addr = row_base + PA_W'(hc);

    // character RAM address once the code has returned
    always_ff @(posedge clk) begin
        if (!rst_n)
            chr_addr <= '0;
        else if (ph == PH_W'(CHR_ADDR_PHASE))
            chr_addr <= {page_data, row};
    end

    // word for the next cell, held until the shifter reloads
    always_ff @(posedge clk) begin
        if (!rst_n)
            next_word <= '0;
        else if (ph == PH_W'(WORD_LATCH_PHASE))
            next_word <= chr_data;
    end

    p_chr_addr_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chr_addr) |-> $past(ph) == PH_W'(CHR_ADDR_PHASE));
endmodule

// File: rtl/vid_shifter.sv
// Pixel serialiser: reloads the cell word at the last phase, shifts it out
// most significant pixel first, and registers colour and blanking.
// Assumes next_word is stable from the latch phase to the end of the cell.
module vid_shifter
    import vidgen_pkg::*;
#(
    parameter int CELL_W  = 6,
    localparam int PH_W   = $clog2(CELL_W),
    localparam int WORD_W = CELL_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PH_W-1:0]   ph,
    input  logic              disp_active,
    input  logic [WORD_W-1:0] next_word,
    input  colour_t           bg,
    output colour_t           pix_colour,
    output logic              pix_blank
);
    logic [CELL_W-1:0] pix_sr;
    colour_t           fg;

    // load at cell end, otherwise shift toward the most significant bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_sr <= '0;
            fg     <= '0;
        end else if (ph == PH_W'(CELL_W - 1)) begin
            pix_sr <= next_word[CELL_W-1:0];
            fg     <= next_word[WORD_W-1:CELL_W];
        end else begin
            pix_sr <= pix_sr << 1;
        end
    end

    // registered colour output with blanking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_colour <= '0;
            pix_blank  <= 1'b1;
        end else if (disp_active) begin
            pix_colour <= pix_sr[CELL_W-1] ? fg : bg;
            pix_blank  <= 1'b0;
        end else begin
            pix_colour <= '0;
            pix_blank  <= 1'b1;
        end
    end

    p_blank_dark_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pix_blank |-> pix_colour == '0);
endmodule

// File: rtl/charcell_vidgen.sv
// Top of the character-cell colour video generator: ties timing, fetch and
// serialiser together. Assumes synchronous page and character RAMs with one-cycle reads.
module charcell_vidgen
    import vidgen_pkg::*;
#(
    parameter int CELL_W        = 6,
    parameter int CELL_H        = 8,
    parameter int H_TOTAL_CELLS = 30,
    parameter int TEXT_ROWS     = 40,
    parameter int V_BLANK_LINES = 8,
    parameter int COLS_NARROW   = 25,
    parameter int COLS_WIDE     = 27
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   wide_mode,
    input  logic [2:0]                             bg_colour,
    output logic [$clog2(TEXT_ROWS*COLS_WIDE)-1:0] page_addr,
    input  logic [7:0]                             page_data,
    output logic [8+$clog2(CELL_H)-1:0]            chr_addr,
    input  logic [CELL_W+2:0]                      chr_data,
    output logic [2:0]                             pix_colour,
    output logic                                   pix_blank,
    output logic                                   predisplay,
    output logic                                   cpu_clk
);
    localparam int PH_W   = $clog2(CELL_W);
    localparam int HC_W   = $clog2(H_TOTAL_CELLS);
    localparam int ROW_W  = $clog2(CELL_H);
    localparam int PA_W   = $clog2(TEXT_ROWS * COLS_WIDE);
    localparam int WORD_W = CELL_W + 3;

    logic [PH_W-1:0]   ph;
    logic [HC_W-1:0]   hc;
    logic [ROW_W-1:0]  row;
    logic [PA_W-1:0]   row_base;
    logic              disp_active;
    logic [WORD_W-1:0] next_word;

    vid_timing #(
        .CELL_W(CELL_W), .CELL_H(CELL_H), .H_TOTAL_CELLS(H_TOTAL_CELLS),
        .TEXT_ROWS(TEXT_ROWS), .V_BLANK_LINES(V_BLANK_LINES),
        .COLS_NARROW(COLS_NARROW), .COLS_WIDE(COLS_WIDE)
    ) u_timing (
        .clk(clk), .rst_n(rst_n), .wide_sel(wide_mode),
        .ph(ph), .hc(hc), .row(row), .row_base(row_base),
        .disp_active(disp_active), .in_vblank(predisplay), .half_clk(cpu_clk)
    );

    vid_fetch #(
        .CELL_W(CELL_W), .CELL_H(CELL_H), .H_TOTAL_CELLS(H_TOTAL_CELLS),
        .TEXT_ROWS(TEXT_ROWS), .COLS_WIDE(COLS_WIDE)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .ph(ph), .hc(hc), .row(row),
        .row_base(row_base), .page_addr(page_addr), .page_data(page_data),
        .chr_addr(chr_addr), .chr_data(chr_data), .next_word(next_word)
    );

    vid_shifter #(.CELL_W(CELL_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .ph(ph), .disp_active(disp_active),
        .next_word(next_word), .bg(bg_colour),
        .pix_colour(pix_colour), .pix_blank(pix_blank)
    );

    p_vblank_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
        predisplay |=> pix_blank);
endmodule

// File: tb/tb_charcell_vidgen.sv
module tb_charcell_vidgen;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wide_mode;
    logic [2:0]  bg_colour;
    logic [10:0] page_addr;
    logic [7:0]  page_data;
    logic [10:0] chr_addr;
    logic [8:0]  chr_data;
    logic [2:0]  pix_colour;
    logic        pix_blank;
    logic        predisplay;
    logic        cpu_clk;

    int checks = 0;
    int errors = 0;

    logic [7:0] page_mem [2048];
    logic [8:0] chr_mem  [2048];

    // reference model state
    int   m_ph, m_hc, m_ln, m_w, m_pos;
    bit   m_cpu, m_live;
    bit   e_blank;
    int   e_col;
    bit   e_clear;
    logic [8:0] m_word;

    always #2 clk = ~clk;

    charcell_vidgen dut (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .bg_colour(bg_colour),
        .page_addr(page_addr), .page_data(page_data),
        .chr_addr(chr_addr), .chr_data(chr_data),
        .pix_colour(pix_colour), .pix_blank(pix_blank),
        .predisplay(predisplay), .cpu_clk(cpu_clk)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // synchronous RAM models with one-cycle read latency
    always @(posedge clk) begin
        page_data <= page_mem[page_addr];
        chr_data  <= chr_mem[chr_addr];
    end

    // behavioural raster model: predicts the registered output, then advances
    always @(posedge clk) begin
        m_live = 1'b1;
        if (!rst_n) begin
            m_ph = 0; m_hc = 0; m_ln = 0; m_cpu = 1'b0;
            m_w = wide_mode ? 27 : 25;
            e_blank = 1'b1; e_col = 0; e_clear = 1'b0;
        end else begin
            if (m_ln < 320 && m_hc >= 1 && m_hc <= m_w) begin
                m_pos   = (m_ln / 8) * m_w + (m_hc - 1);
                m_word  = chr_mem[int'(page_mem[m_pos]) * 8 + m_ln % 8];
                e_blank = 1'b0;
                e_clear = !m_word[5 - m_ph];
                e_col   = e_clear ? int'(bg_colour) : int'(m_word[8:6]);
            end else begin
                e_blank = 1'b1; e_col = 0; e_clear = 1'b0;
            end
            m_cpu = !m_cpu;
            m_ph++;
            if (m_ph == 6) begin
                m_ph = 0; m_hc++;
                if (m_hc == 30) begin
                    m_hc = 0; m_ln++;
                    if (m_ln == 328) begin
                        m_ln = 0;
                        m_w = wide_mode ? 27 : 25;
                    end
                end
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (m_live) begin
            if (m_hc >= 25 && m_hc <= 28)
                chk(pix_blank == e_blank, "R8 width edge blank", int'(pix_blank), int'(e_blank));
            else
                chk(pix_blank == e_blank, "R6 blank", int'(pix_blank), int'(e_blank));
            if (e_blank)
                chk(pix_colour == 3'd0, "R6 blank colour", int'(pix_colour), 0);
            else if (e_clear)
                chk(int'(pix_colour) == e_col, "R9 background pixel", int'(pix_colour), e_col);
            else
                chk(int'(pix_colour) == e_col, "R5 foreground pixel", int'(pix_colour), e_col);
            chk(cpu_clk == m_cpu, "R2 cpu clock", int'(cpu_clk), int'(m_cpu));
            chk(predisplay == (m_ln >= 320), "R7 predisplay", int'(predisplay), int'(m_ln >= 320));
            if (rst_n && m_ln < 320 && m_hc < m_w && m_ph == 0)
                chk(int'(page_addr) == (m_ln / 8) * m_w + m_hc, "R3 page address",
                    int'(page_addr), (m_ln / 8) * m_w + m_hc);
            if (rst_n && m_ln < 320 && m_hc < m_w && m_ph == 2) begin
                m_pos = (m_ln / 8) * m_w + m_hc;
                chk(int'(chr_addr) == int'(page_mem[m_pos]) * 8 + m_ln % 8, "R4 char address",
                    int'(chr_addr), int'(page_mem[m_pos]) * 8 + m_ln % 8);
            end
        end
    end

    initial begin
        for (int i = 0; i < 2048; i++) begin
            page_mem[i] = 8'((i * 37 + i / 5) % 256);
            chr_mem[i]  = 9'(((i * 53) ^ ((i >> 3) * 7) ^ (i >> 5)) % 512);
        end
        chr_mem[0] = 9'h1FF;
        chr_mem[8] = 9'h0C0;
        rst_n = 1'b0; wide_mode = 1'b0; bg_colour = 3'd3;
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(pix_blank == 1'b1, "R1 reset blank", int'(pix_blank), 1);
        chk(pix_colour == 3'd0, "R1 reset colour", int'(pix_colour), 0);
        chk(predisplay == 1'b0, "R1 reset predisplay", int'(predisplay), 0);
        chk(cpu_clk == 1'b0, "R1 reset cpu clock", int'(cpu_clk), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pix_blank == 1'b1, "R1 first cycle blank", int'(pix_blank), 1);
        // width change mid-frame must wait for the frame boundary (R8)
        repeat (20000) @(negedge clk);
        wide_mode = 1'b1; bg_colour = 3'd5;
        repeat (45000) @(negedge clk);
        wide_mode = 1'b0; bg_colour = 3'd6;
        repeat (20000) @(negedge clk);
        bg_colour = 3'd1;
        repeat (40000) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule